// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This block decodes each external bus cycle against a small set of channels. Every channel holds a base address and a power-of-two block size. When a request arrives, the unit finds the matching channel and drives that channel's active-low select. It pulses an active-low address-valid line for flash parts and then drives a read or write strobe for a programmed number of wait states. For the whole cycle it reports the channel's port width, so that a separate sizing stage can split wide accesses.

Each channel can refuse user-mode accesses, and it can refuse writes when marked read-only. A refused access, or an address that no enabled channel claims, raises no select and no strobe. The cycle instead ends with a one-clock transfer error. A bus master presents one request at a time. It sees the end of the cycle on the acknowledge or the error output.

Top module: `csel_unit`

## Requirements
- R1: After reset every select, the address-valid line and both strobes are high; acknowledge, error and busy are low, and all channels are disabled.
- R2: Configuration writes use cfg_sel=0 for the base (byte address in cfg_wdata[AW-1:0]) and cfg_sel=1 for the control word: [3:0] primary wait count, [7:4] secondary wait count, [9:8] width code, [10] user block, [11] read-only, [12] enable, [20:16] log2 of the block size, clamped to MIN_SZ..AW. An enabled channel matches an address whose bits above the block size equal its base.
- R3: A base address that is not aligned to the block size is stored masked down to the aligned boundary, so addresses below the written value but inside the aligned block still match.
- R4: When several enabled channels match, only the lowest-numbered one asserts its select, and at most one select is ever low.
- R5: Address-valid is low for exactly the first clock of a selected cycle, together with the select, and with both strobes high.
- R6: From the second clock, the output enable (reads) or the write enable (writes) stays low for the primary wait count plus one clocks. Acknowledge is high on the last of those clocks, and the select is released after it.
- R7: A request flagged as a later beat (req_burst=1) uses the secondary wait count instead of the primary one.
- R8: While the select is low, port_width carries the channel's width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
- R9: A user-mode request (req_user=1) to a channel with the user block set asserts no select, address-valid or strobe. It raises the error output for exactly one clock, the clock after the request is taken.
- R10: A write to a read-only channel is refused as in R9; a read to the same channel completes normally.
- R11: An address that no enabled channel claims, including one inside a disabled channel, is refused as in R9. Once that channel is enabled, the same address completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel being configured |
| cfg_sel | input | 1 | 0 = base register, 1 = control register |
| cfg_wdata | input | DW | Configuration write data |
| req_valid | input | 1 | Bus request, taken while the unit is idle |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user-mode access |
| req_burst | input | 1 | 1 = later beat, uses the secondary wait count |
| busy | output | 1 | A cycle is in progress |
| cs_n | output | NCH | Active-low channel selects |
| adv_n | output | 1 | Active-low address valid |
| oe_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |
| port_width | output | 2 | Width code of the selected channel |
| ack | output | 1 | Last strobe clock of a completed cycle |
| terr | output | 1 | One-clock transfer error |

## Verification
A request taken on clock edge k shows its select, width and address-valid after edge k. The strobe follows from edge k+1 for wait+1 clocks, and acknowledge comes on the last strobe clock. A refused request shows its error only in the clock after edge k. The monitor samples every falling edge, so it sees each of these clock-wide phases exactly once. It rebuilds the observed cycle as channel, direction, width and strobe length, or as an error, and compares the result with the next queued expectation. The driver does not present a new request until busy has dropped, so the expectation queue and the observed cycles stay in step.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int WAIT_W = 4;
    localparam int SZ_W   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_ERR  = 2'd3
    } st_e;

    typedef struct packed {
        logic              enable;
        logic              ronly;
        logic              ublock;
        logic [1:0]        width;
        logic [SZ_W-1:0]   size_log2;
        logic [WAIT_W-1:0] wait2;
        logic [WAIT_W-1:0] wait1;
    } chcfg_t;

endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int AW     = 24,
    parameter int DW     = 32,
    parameter int MIN_SZ = 8,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CHW-1:0]         cfg_ch,
    input  logic                   cfg_sel,
    input  logic [DW-1:0]          cfg_wdata,
    output chcfg_t [NCH-1:0]       cfg_o,
    output logic [NCH-1:0][AW-1:0] base_o
);

    localparam logic [SZ_W-1:0] SZ_LO = SZ_W'(MIN_SZ);
    localparam logic [SZ_W-1:0] SZ_HI = SZ_W'(AW);

    function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] k);
        if (k < SZ_LO) return SZ_LO;
        if (k > SZ_HI) return SZ_HI;
        return k;
    endfunction

    function automatic logic [AW-1:0] align_mask(input logic [SZ_W-1:0] k);
        return {AW{1'b1}} << k;
    endfunction

    chcfg_t wr_cfg;
    always_comb begin
        wr_cfg.wait1     = cfg_wdata[3:0];
        wr_cfg.wait2     = cfg_wdata[7:4];
        wr_cfg.width     = cfg_wdata[9:8];
        wr_cfg.ublock    = cfg_wdata[10];
        wr_cfg.ronly     = cfg_wdata[11];
        wr_cfg.enable    = cfg_wdata[12];
        wr_cfg.size_log2 = clamp_sz(cfg_wdata[20:16]);
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[DW-1:21], cfg_wdata[15:13]};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chcfg_t          cfg_d, cfg_q;
        logic [AW-1:0]   base_d, base_q;
        logic            hit_w;

        assign hit_w = cfg_we && (cfg_ch == CHW'(i));

        always_comb begin
            cfg_d  = cfg_q;
            base_d = base_q;
            if (hit_w && cfg_sel) begin
                cfg_d  = wr_cfg;
                base_d = base_q & align_mask(wr_cfg.size_log2);
            end else if (hit_w) begin
                base_d = cfg_wdata[AW-1:0] & align_mask(cfg_q.size_log2);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q           <= '0;
                cfg_q.size_log2 <= SZ_LO;
                base_q          <= '0;
            end else begin
                cfg_q  <= cfg_d;
                base_q <= base_d;
            end
        end

        assign cfg_o[i]  = cfg_q;
        assign base_o[i] = base_q;
    end

endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 24,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0]          addr,
    input  chcfg_t [NCH-1:0]       cfg,
    input  logic [NCH-1:0][AW-1:0] base,
    output logic                   hit,
    output logic [CHW-1:0]         hit_ch
);

    logic [NCH-1:0] claim;

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic [AW-1:0] m;
        assign m        = {AW{1'b1}} << cfg[i].size_log2;
        assign claim[i] = cfg[i].enable && (((addr ^ base[i]) & m) == '0);
    end

    // Scan from the top so the lowest claiming channel is the last one kept.
    always_comb begin
        hit    = 1'b0;
        hit_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (claim[i]) begin
                hit    = 1'b1;
                hit_ch = CHW'(i);
            end
        end
    end

endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int AW     = 24,
    parameter int DW     = 32,
    parameter int MIN_SZ = 8,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic            cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic            req_user,
    input  logic            req_burst,
    output logic            busy,
    output logic [NCH-1:0]  cs_n,
    output logic            adv_n,
    output logic            oe_n,
    output logic            we_n,
    output logic [1:0]      port_width,
    output logic            ack,
    output logic            terr
);

    chcfg_t [NCH-1:0]       cfg;
    logic [NCH-1:0][AW-1:0] base;
    logic                   hit;
    logic [CHW-1:0]         hit_ch;

    csel_regs #(.NCH(NCH), .AW(AW), .DW(DW), .MIN_SZ(MIN_SZ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg),
        .base_o    (base)
    );

    csel_match #(.NCH(NCH), .AW(AW)) u_match (
        .addr   (req_addr),
        .cfg    (cfg),
        .base   (base),
        .hit    (hit),
        .hit_ch (hit_ch)
    );

    typedef struct packed {
        st_e               st;
        logic [CHW-1:0]    ch;
        logic              wr;
        logic [WAIT_W-1:0] cnt;
        logic [1:0]        width;
    } seq_t;

    seq_t   s_d, s_q;
    chcfg_t sel_cfg;
    logic   refuse;

    assign sel_cfg = cfg[hit_ch];
    assign refuse  = !hit
                   || (sel_cfg.ublock && req_user)
                   || (sel_cfg.ronly && req_write);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (refuse) begin
                        s_d.st = ST_ERR;
                    end else begin
                        s_d.st    = ST_ADDR;
                        s_d.ch    = hit_ch;
                        s_d.wr    = req_write;
                        s_d.width = sel_cfg.width;
                        s_d.cnt   = req_burst ? sel_cfg.wait2 : sel_cfg.wait1;
                    end
                end
            end
            ST_ADDR: s_d.st = ST_STRB;
            ST_STRB: begin
                if (s_q.cnt == '0) s_d.st = ST_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_ERR:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    logic in_cycle;
    assign in_cycle = (s_q.st == ST_ADDR) || (s_q.st == ST_STRB);

    always_comb begin
        cs_n = '1;
        if (in_cycle) cs_n[s_q.ch] = 1'b0;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign adv_n      = (s_q.st != ST_ADDR);
    assign oe_n       = !((s_q.st == ST_STRB) && !s_q.wr);
    assign we_n       = !((s_q.st == ST_STRB) && s_q.wr);
    assign port_width = in_cycle ? s_q.width : 2'd0;
    assign ack        = (s_q.st == ST_STRB) && (s_q.cnt == '0);
    assign terr       = (s_q.st == ST_ERR);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R4
    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |=> adv_n); // R5
    AST_ADV_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |-> ((~cs_n != '0) && oe_n && we_n)); // R5
    AST_ADV_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |=> (!oe_n || !we_n)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n || we_n); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (oe_n && we_n && (&cs_n))); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        terr |-> ((&cs_n) && adv_n && oe_n && we_n)); // R9
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        terr |=> !terr); // R9
    AST_CS_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (port_width == 2'd0)); // R8

endmodule

// File: tb/sim_csel_unit.sv
`timescale 1ns/1ps
module sim_csel_unit;

    localparam int NCH = 4;
    localparam int AW  = 24;
    localparam int DW  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_ch = '0;
    logic            cfg_sel = 1'b0;
    logic [DW-1:0]   cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic            req_write = 1'b0;
    logic            req_user = 1'b0;
    logic            req_burst = 1'b0;
    logic            busy;
    logic [NCH-1:0]  cs_n;
    logic            adv_n, oe_n, we_n, ack, terr;
    logic [1:0]      port_width;

    always #2.5 clk = ~clk;

    csel_unit #(.NCH(NCH), .AW(AW), .DW(DW), .MIN_SZ(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
        .req_burst(req_burst), .busy(busy), .cs_n(cs_n), .adv_n(adv_n),
        .oe_n(oe_n), .we_n(we_n), .port_width(port_width), .ack(ack),
        .terr(terr)
    );

    typedef struct packed {
        logic       err;
        logic [1:0] ch;
        logic       wr;
        logic [1:0] w;
        logic [7:0] n;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    function automatic logic [31:0] ctrl(input int w1, input int w2, input int wc,
                                         input bit ub, input bit ro, input bit en,
                                         input int sz);
        logic [31:0] v = '0;
        v[3:0]   = 4'(w1);
        v[7:4]   = 4'(w2);
        v[9:8]   = 2'(wc);
        v[10]    = ub;
        v[11]    = ro;
        v[12]    = en;
        v[20:16] = 5'(sz);
        return v;
    endfunction

    task automatic cfg_write(input int ch, input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: queue the expected cycle, present the request, wait for idle.
    task automatic bus(input logic [AW-1:0] a, input bit wr, input bit usr,
                       input bit bst, input item_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        req_user = usr; req_burst = bst;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    function automatic item_t ok(input int ch, input bit wr, input int w, input int wt);
        item_t e;
        e.err = 1'b0; e.ch = 2'(ch); e.wr = wr; e.w = 2'(w); e.n = 8'(wt + 1);
        return e;
    endfunction

    function automatic item_t bad();
        return '{err: 1'b1, default: '0};
    endfunction

    // Monitor: rebuild each cycle from the pins and compare with the queue.
    bit    in_txn = 1'b0;
    item_t obs;

    task automatic compare(input item_t o);
        item_t e;
        string t;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected cycle: actual %h expected none", o);
            return;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (o !== e) begin
            n_bad++;
            $display("FAIL %s: actual err=%0d ch=%0d wr=%0d w=%0d n=%0d expected err=%0d ch=%0d wr=%0d w=%0d n=%0d",
                     t, o.err, o.ch, o.wr, o.w, o.n, e.err, e.ch, e.wr, e.w, e.n);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (terr) begin
                obs = bad();
                if (!(&cs_n) || in_txn) obs.n = 8'hFF; // R9: no select during an error
                compare(obs);
            end else if (!adv_n) begin
                in_txn  = 1'b1;
                obs     = '0;
                obs.w   = port_width;
                for (int i = 0; i < NCH; i++) if (!cs_n[i]) obs.ch = 2'(i);
                if (!oe_n || !we_n) obs.n = 8'hEE; // R5: no strobe on the first clock
            end else if (in_txn) begin
                if (!oe_n || !we_n) begin
                    obs.n  = obs.n + 8'd1;
                    obs.wr = !we_n;
                    if (port_width != obs.w) obs.w = 2'd3; // R8: width held
                end
                if (ack) begin
                    in_txn = 1'b0;
                    compare(obs);
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (cs_n !== '1 || adv_n !== 1'b1 || oe_n !== 1'b1 || we_n !== 1'b1 ||
            ack !== 1'b0 || terr !== 1'b0 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual cs=%b adv=%b oe=%b we=%b ack=%b terr=%b busy=%b expected all idle",
                     cs_n, adv_n, oe_n, we_n, ack, terr, busy);
        end
        // R11: before any enable, everything is refused
        bus(24'h000100, 1'b0, 1'b0, 1'b0, bad(), "R11 disabled at reset");

        // R2 configuration
        cfg_write(0, 1'b1, ctrl(2, 1, 2, 0, 0, 1, 12));
        cfg_write(0, 1'b0, 32'h000000);
        cfg_write(1, 1'b1, ctrl(0, 3, 1, 1, 0, 1, 16));
        cfg_write(1, 1'b0, 32'h012345);          // R3: unaligned, masked to 0x010000
        cfg_write(2, 1'b1, ctrl(1, 0, 0, 0, 1, 1, 20));
        cfg_write(2, 1'b0, 32'h000000);
        cfg_write(3, 1'b1, ctrl(0, 0, 2, 0, 0, 0, 12));
        cfg_write(3, 1'b0, 32'h200000);

        bus(24'h000100, 1'b0, 1'b0, 1'b0, ok(0, 0, 2, 2), "R2 R4 R6 read ch0");
        bus(24'h000FFC, 1'b1, 1'b0, 1'b0, ok(0, 1, 2, 2), "R6 write ch0");
        bus(24'h000104, 1'b0, 1'b0, 1'b1, ok(0, 0, 2, 1), "R7 burst ch0");
        bus(24'h010000, 1'b0, 1'b0, 1'b0, ok(1, 0, 1, 0), "R3 masked base");
        bus(24'h01FFFF, 1'b0, 1'b0, 1'b1, ok(1, 0, 1, 3), "R7 burst ch1");
        bus(24'h010010, 1'b0, 1'b1, 1'b0, bad(), "R9 user block");
        bus(24'h010020, 1'b1, 1'b0, 1'b0, ok(1, 1, 1, 0), "R8 write ch1");
        bus(24'h002000, 1'b0, 1'b0, 1'b0, ok(2, 0, 0, 1), "R4 R8 outside ch0");
        bus(24'h002000, 1'b1, 1'b0, 1'b0, bad(), "R10 read-only write");
        bus(24'h200000, 1'b0, 1'b0, 1'b0, bad(), "R11 disabled ch3");
        bus(24'h300000, 1'b0, 1'b0, 1'b0, bad(), "R11 no match");
        bus(24'h000200, 1'b0, 1'b1, 1'b0, ok(0, 0, 2, 2), "R9 user allowed ch0");
        bus(24'h0F0000, 1'b0, 1'b0, 1'b1, ok(2, 0, 0, 0), "R10 read ok ch2");

        cfg_write(3, 1'b1, ctrl(0, 0, 2, 0, 0, 1, 12));
        bus(24'h200010, 1'b0, 1'b0, 1'b0, ok(3, 0, 2, 0), "R11 enabled ch3");

        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0 || in_txn) begin
            n_bad++;
            $display("FAIL R6: actual %0d cycles pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule